// File: doc/BRIEF.md
# Pipeline Control Path with Load-Use Interlock

This block is the control side of a five-stage in-order integer pipeline. It decodes the opcode held in the fetch/decode register into one bundle of controls. The bundle is then carried down the pipeline registers, so that execute, memory and writeback each act only on the controls of the instruction they currently hold. The execute part covers extend select, ALU source, ALU operation and destination select. The memory part covers memory write, memory read and branch. The writeback part covers memory-to-register and register write. The destination register number is chosen in execute and travels with the bundle.

The block also keeps track of register numbers in flight. It detects a load whose result is needed by the very next instruction. In that case it holds the PC and the fetch/decode register for one cycle and sends an all-zero bundle into execute, which makes a single bubble. For the instruction in execute it drives two operand-forwarding selects. The register file is assumed to return the written value on a same-cycle read, so nothing is forwarded into decode. The ALU, the memories and the register file are outside this block.

Top module: `pipe_ctrl_top`

## Requirements
- R1: Opcode decode (4-bit). Each opcode gives controls in the order {extSel, aluSrc, aluOp[1:0], dstSel} / {memWrite, memRead, branch} / {memToReg, regWrite}:
  - 0 NOP: 00000/000/00
  - 1 ADD: 00001/000/01
  - 2 SUB: 00011/000/01
  - 3 AND: 00101/000/01
  - 4 OR: 00111/000/01
  - 5 ADDI: 11000/000/01
  - 6 ORI: 01110/000/01
  - 7 LOAD: 11000/010/11
  - 8 STORE: 11000/100/00
  - 9 BEQ: 00010/001/00
  - Any other code: all zero.
- R2: The execute controls of an instruction appear on the ex outputs one clock after it is presented at decode.
- R3: The memory controls appear on the mem outputs two clocks after decode.
- R4: The writeback controls appear on the wb outputs three clocks after decode. At the same time wbDest shows rd when dstSel is 1 and rt when dstSel is 0.
- R5: holdFetch is 1 in the same cycle that execute holds an instruction with both regWrite and memRead set, whose nonzero destination equals idRs or idRt.
- R6: A stall inserts exactly one bubble: on the next cycle all ex outputs are 0 and holdFetch is 0. The held instruction then enters execute one cycle later.
- R7: fwdA (for the execute rs) and fwdB (for the execute rt) use these codes: 2 = take from the execute/memory register, 1 = take from the memory/writeback register, 0 = register file. A match counts only when the producer has regWrite set.
- R8: When both the memory-stage and the writeback-stage producer match a source, the select is 2.
- R9: Register 0 is never forwarded, and a load to register 0 never stalls.
- R10: A synchronous reset clears every stage bundle and destination. All control outputs, holdFetch and both selects then read 0.
- R11: A producer that has left writeback is not forwarded. An instruction three slots behind its producer gets select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idOpcode | input | 4 | Opcode of the instruction in decode |
| idRs | input | REG_W | First source register in decode |
| idRt | input | REG_W | Second source / immediate destination in decode |
| idRd | input | REG_W | Register-form destination in decode |
| holdFetch | output | 1 | Hold PC and fetch/decode register |
| exExtSel | output | 1 | Execute: sign (1) or zero (0) extend |
| exAluSrc | output | 1 | Execute: immediate as second ALU operand |
| exAluOp | output | 2 | Execute: 0 add, 1 sub, 2 and, 3 or |
| exDstSel | output | 1 | Execute: destination is rd (1) or rt (0) |
| memWrite | output | 1 | Memory: store strobe |
| memRead | output | 1 | Memory: load strobe |
| memBranch | output | 1 | Memory: branch instruction |
| wbMemToReg | output | 1 | Writeback: choose memory data |
| wbRegWrite | output | 1 | Writeback: register write enable |
| wbDest | output | REG_W | Writeback: destination register number |
| fwdA | output | 2 | Forward select for execute rs |
| fwdB | output | 2 | Forward select for execute rt |

## Verification
The hardest state to reach is a load in execute while its consumer waits in decode. This state must then be followed by the bubble and by the consumer arriving in execute exactly as the load reaches writeback. Only the exact slot spacing of the stimulus produces it. The bench presents the load and then the dependent instruction in back-to-back cycles, and keeps the decode inputs unchanged across the hold, as a held fetch register would. It then checks the stall, the bubble and the writeback-path select on the three following cycles. Priority between the two forwarding paths is reached by issuing two writers of the same register back to back, ahead of a reader.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP   = 4'd0;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'd1;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'd2;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_OR    = 4'd4;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_ORI   = 4'd6;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd7;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'd8;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 4'd9;

  typedef struct packed {
    logic       extSel;
    logic       aluSrc;
    logic [1:0] aluOp;
    logic       dstSel;
  } exCtl_t;

  typedef struct packed {
    logic memWrite;
    logic memRead;
    logic branch;
  } memCtl_t;

  typedef struct packed {
    logic memToReg;
    logic regWrite;
  } wbCtl_t;

  typedef struct packed {
    exCtl_t  ex;
    memCtl_t mem;
    wbCtl_t  wb;
  } ctlBundle_t;

  // strobes from the interlock to the stage registers
  typedef struct packed {
    logic holdFetch;
    logic bubble;
  } strobe_t;

  typedef enum logic [1:0] {
    FWD_RF    = 2'd0,
    FWD_MEMWB = 2'd1,
    FWD_EXMEM = 2'd2
  } fwdSel_t;
endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
  import pctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctlBundle_t       bundle
);
  always_comb begin
    bundle = '0;
    unique case (opcode)
      OPC_ADD:   begin bundle.ex = '{1'b0, 1'b0, 2'd0, 1'b1}; bundle.wb.regWrite = 1'b1; end
      OPC_SUB:   begin bundle.ex = '{1'b0, 1'b0, 2'd1, 1'b1}; bundle.wb.regWrite = 1'b1; end
      OPC_AND:   begin bundle.ex = '{1'b0, 1'b0, 2'd2, 1'b1}; bundle.wb.regWrite = 1'b1; end
      OPC_OR:    begin bundle.ex = '{1'b0, 1'b0, 2'd3, 1'b1}; bundle.wb.regWrite = 1'b1; end
      OPC_ADDI:  begin bundle.ex = '{1'b1, 1'b1, 2'd0, 1'b0}; bundle.wb.regWrite = 1'b1; end
      OPC_ORI:   begin bundle.ex = '{1'b0, 1'b1, 2'd3, 1'b0}; bundle.wb.regWrite = 1'b1; end
      OPC_LOAD:  begin
        bundle.ex = '{1'b1, 1'b1, 2'd0, 1'b0};
        bundle.mem.memRead = 1'b1;
        bundle.wb = '{1'b1, 1'b1};
      end
      OPC_STORE: begin bundle.ex = '{1'b1, 1'b1, 2'd0, 1'b0}; bundle.mem.memWrite = 1'b1; end
      OPC_BEQ:   begin bundle.ex = '{1'b0, 1'b0, 2'd1, 1'b0}; bundle.mem.branch = 1'b1; end
      default:   bundle = '0;
    endcase
  end

  // R1: a no-op must leave every control benign
  a_r1_nop_benign: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_NOP) |-> (bundle == '0));

  // R1: stores never write the register file
  a_r1_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_STORE) |-> (!bundle.wb.regWrite && bundle.mem.memWrite));
endmodule

// File: rtl/pctl_stages.sv
module pctl_stages
  import pctl_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobe,
  input  ctlBundle_t       idBundle,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic [REG_W-1:0] idRd,
  output ctlBundle_t       exBundle,
  output logic [REG_W-1:0] exRs,
  output logic [REG_W-1:0] exRt,
  output logic [REG_W-1:0] exDest,
  output memCtl_t          memCtl,
  output wbCtl_t           memWbCtl,
  output logic [REG_W-1:0] memDest,
  output wbCtl_t           wbCtl,
  output logic [REG_W-1:0] wbDest
);
  logic [REG_W-1:0] exRd;

  // decode -> execute: the bubble zeroes the bundle and the register fields
  always_ff @(posedge clk) begin
    if (rst || strobe.bubble) begin
      exBundle <= '0;
      exRs     <= '0;
      exRt     <= '0;
      exRd     <= '0;
    end else begin
      exBundle <= idBundle;
      exRs     <= idRs;
      exRt     <= idRt;
      exRd     <= idRd;
    end
  end

  // the destination select is an execute control
  assign exDest = exBundle.ex.dstSel ? exRd : exRt;

  // execute -> memory: the execute part is dropped here
  always_ff @(posedge clk) begin
    if (rst) begin
      memCtl   <= '0;
      memWbCtl <= '0;
      memDest  <= '0;
    end else begin
      memCtl   <= exBundle.mem;
      memWbCtl <= exBundle.wb;
      memDest  <= exDest;
    end
  end

  // memory -> writeback
  always_ff @(posedge clk) begin
    if (rst) begin
      wbCtl  <= '0;
      wbDest <= '0;
    end else begin
      wbCtl  <= memWbCtl;
      wbDest <= memDest;
    end
  end

  // R10: reset leaves every stage benign
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (exBundle == '0 && memCtl == '0 && memWbCtl == '0 && wbCtl == '0));

  // R6: a requested bubble reaches execute as an all-zero bundle
  a_r6_bubble_zero: assert property (@(posedge clk) disable iff (rst)
    strobe.bubble |=> (exBundle == '0));
endmodule

// File: rtl/pctl_hazard.sv
module pctl_hazard
  import pctl_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             exRegWrite,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] exDest,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memDest,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] wbDest,
  output strobe_t          strobe,
  output fwdSel_t          fwdA,
  output fwdSel_t          fwdB
);
  localparam int NUM_SRC = 2;

  logic loadUse;
  logic [REG_W-1:0] exSrc [NUM_SRC];
  fwdSel_t          fwdSel [NUM_SRC];

  assign loadUse = exRegWrite && exMemRead && (exDest != '0) &&
                   ((exDest == idRs) || (exDest == idRt));

  assign strobe.holdFetch = loadUse;
  assign strobe.bubble    = loadUse;

  assign exSrc[0] = exRs;
  assign exSrc[1] = exRt;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
    logic hitMem, hitWb;
    assign hitMem = memRegWrite && (memDest != '0) && (memDest == exSrc[i]);
    assign hitWb  = wbRegWrite  && (wbDest  != '0) && (wbDest  == exSrc[i]);
    assign fwdSel[i] = hitMem ? FWD_EXMEM : (hitWb ? FWD_MEMWB : FWD_RF);
  end

  assign fwdA = fwdSel[0];
  assign fwdB = fwdSel[1];

  // R6: the interlock never holds two cycles in a row
  a_r6_single_stall: assert property (@(posedge clk) disable iff (rst)
    strobe.holdFetch |=> !strobe.holdFetch);

  // R5: a stall is only ever caused by a load sitting in execute
  a_r5_stall_needs_load: assert property (@(posedge clk) disable iff (rst)
    strobe.holdFetch |-> (exMemRead && exRegWrite));

  // R9: register 0 is never a forwarding source
  a_r9_no_zero_fwd: assert property (@(posedge clk) disable iff (rst)
    ((fwdA != FWD_RF) |-> (exRs != '0)) and ((fwdB != FWD_RF) |-> (exRt != '0)));

  // R8: the younger producer wins when both match
  a_r8_exmem_priority: assert property (@(posedge clk) disable iff (rst)
    (memRegWrite && wbRegWrite && memDest == wbDest && memDest == exRs && exRs != '0)
      |-> (fwdA == FWD_EXMEM));
endmodule

// File: rtl/pipe_ctrl_top.sv
module pipe_ctrl_top
  import pctl_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       idOpcode,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic [REG_W-1:0] idRd,
  output logic             holdFetch,
  output logic             exExtSel,
  output logic             exAluSrc,
  output logic [1:0]       exAluOp,
  output logic             exDstSel,
  output logic             memWrite,
  output logic             memRead,
  output logic             memBranch,
  output logic             wbMemToReg,
  output logic             wbRegWrite,
  output logic [REG_W-1:0] wbDest,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB
);
  ctlBundle_t       idBundle, exBundle;
  memCtl_t          memCtl;
  wbCtl_t           memWbCtl, wbCtl;
  strobe_t          strobe;
  logic [REG_W-1:0] exRs, exRt, exDest, memDest;
  fwdSel_t          selA, selB;

  pctl_decode u_decode (
    .clk    (clk),
    .rst    (rst),
    .opcode (idOpcode),
    .bundle (idBundle)
  );

  pctl_stages #(.REG_W(REG_W)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .idBundle (idBundle),
    .idRs     (idRs),
    .idRt     (idRt),
    .idRd     (idRd),
    .exBundle (exBundle),
    .exRs     (exRs),
    .exRt     (exRt),
    .exDest   (exDest),
    .memCtl   (memCtl),
    .memWbCtl (memWbCtl),
    .memDest  (memDest),
    .wbCtl    (wbCtl),
    .wbDest   (wbDest)
  );

  pctl_hazard #(.REG_W(REG_W)) u_hazard (
    .clk         (clk),
    .rst         (rst),
    .idRs        (idRs),
    .idRt        (idRt),
    .exRegWrite  (exBundle.wb.regWrite),
    .exMemRead   (exBundle.mem.memRead),
    .exRs        (exRs),
    .exRt        (exRt),
    .exDest      (exDest),
    .memRegWrite (memWbCtl.regWrite),
    .memDest     (memDest),
    .wbRegWrite  (wbCtl.regWrite),
    .wbDest      (wbDest),
    .strobe      (strobe),
    .fwdA        (selA),
    .fwdB        (selB)
  );

  assign holdFetch  = strobe.holdFetch;
  assign exExtSel   = exBundle.ex.extSel;
  assign exAluSrc   = exBundle.ex.aluSrc;
  assign exAluOp    = exBundle.ex.aluOp;
  assign exDstSel   = exBundle.ex.dstSel;
  assign memWrite   = memCtl.memWrite;
  assign memRead    = memCtl.memRead;
  assign memBranch  = memCtl.branch;
  assign wbMemToReg = wbCtl.memToReg;
  assign wbRegWrite = wbCtl.regWrite;
  assign fwdA       = selA;
  assign fwdB       = selB;
endmodule

// File: tb/pipe_ctrl_top_test.sv
`timescale 1ns/1ps
module pipe_ctrl_top_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] idOpcode;
  logic [4:0] idRs, idRt, idRd;
  logic       holdFetch, exExtSel, exAluSrc, exDstSel;
  logic [1:0] exAluOp, fwdA, fwdB;
  logic       memWrite, memRead, memBranch, wbMemToReg, wbRegWrite;
  logic [4:0] wbDest;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pipe_ctrl_top #(.REG_W(5)) uut (
    .clk(clk), .rst(rst), .idOpcode(idOpcode), .idRs(idRs), .idRt(idRt), .idRd(idRd),
    .holdFetch(holdFetch), .exExtSel(exExtSel), .exAluSrc(exAluSrc), .exAluOp(exAluOp),
    .exDstSel(exDstSel), .memWrite(memWrite), .memRead(memRead), .memBranch(memBranch),
    .wbMemToReg(wbMemToReg), .wbRegWrite(wbRegWrite), .wbDest(wbDest),
    .fwdA(fwdA), .fwdB(fwdB)
  );

  // {op, rs, rt, rd, ex{ext,src,op,dst}, mem{wr,rd,br}, wb{m2r,we}, dest}
  localparam int NV = 11;
  localparam logic [33:0] VEC [NV] = '{
    {4'd0,  5'd1,  5'd2,  5'd3,  5'b00000, 3'b000, 2'b00, 5'd2},
    {4'd1,  5'd1,  5'd2,  5'd3,  5'b00001, 3'b000, 2'b01, 5'd3},
    {4'd2,  5'd4,  5'd5,  5'd6,  5'b00011, 3'b000, 2'b01, 5'd6},
    {4'd3,  5'd7,  5'd8,  5'd9,  5'b00101, 3'b000, 2'b01, 5'd9},
    {4'd4,  5'd10, 5'd11, 5'd12, 5'b00111, 3'b000, 2'b01, 5'd12},
    {4'd5,  5'd13, 5'd14, 5'd15, 5'b11000, 3'b000, 2'b01, 5'd14},
    {4'd6,  5'd16, 5'd17, 5'd18, 5'b01110, 3'b000, 2'b01, 5'd17},
    {4'd7,  5'd19, 5'd20, 5'd21, 5'b11000, 3'b010, 2'b11, 5'd20},
    {4'd8,  5'd22, 5'd23, 5'd24, 5'b11000, 3'b100, 2'b00, 5'd23},
    {4'd9,  5'd25, 5'd26, 5'd27, 5'b00010, 3'b001, 2'b00, 5'd26},
    {4'd15, 5'd28, 5'd29, 5'd30, 5'b00000, 3'b000, 2'b00, 5'd29}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [4:0] s, input logic [4:0] t,
                       input logic [4:0] d);
    idOpcode = op; idRs = s; idRt = t; idRd = d;
    #1;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain;
    issue(4'd0, 5'd0, 5'd0, 5'd0);
    repeat (4) step();
  endtask

  function automatic logic [4:0] exPack();
    return {exExtSel, exAluSrc, exAluOp, exDstSel};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idOpcode = 4'd0; idRs = '0; idRt = '0; idRd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 reset ex", {27'd0, exPack()}, 32'd0);
    check("R10 reset mem/wb", {memWrite, memRead, memBranch, wbMemToReg, wbRegWrite}, 32'd0);
    check("R10 reset hold/fwd", {holdFetch, fwdA, fwdB}, 32'd0);
    rst = 1'b0;

    // R1..R4: walk the decode table through the stages
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      issue(v[33:30], v[29:25], v[24:20], v[19:15]);
      step();
      check($sformatf("R2/R1 ex controls op%0d", v[33:30]), {27'd0, exPack()}, {27'd0, v[14:10]});
      issue(4'd0, 5'd0, 5'd0, 5'd0);
      step();
      check($sformatf("R3/R1 mem controls op%0d", v[33:30]),
            {29'd0, memWrite, memRead, memBranch}, {29'd0, v[9:7]});
      step();
      check($sformatf("R4/R1 wb controls op%0d", v[33:30]),
            {30'd0, wbMemToReg, wbRegWrite}, {30'd0, v[6:5]});
      check($sformatf("R4 wb dest op%0d", v[33:30]), {27'd0, wbDest}, {27'd0, v[4:0]});
    end
    drain();

    // R5/R6/R7: load then dependent use through rs
    issue(4'd7, 5'd2, 5'd3, 5'd0);
    step();
    issue(4'd1, 5'd3, 5'd4, 5'd6);
    check("R5 stall on rs match", {31'd0, holdFetch}, 32'd1);
    step();
    check("R6 bubble ex zero", {27'd0, exPack()}, 32'd0);
    check("R6 hold released", {31'd0, holdFetch}, 32'd0);
    step();
    check("R6 held add enters ex", {27'd0, exPack()}, 32'd1);
    check("R7 fwdA from mem/wb after load", {30'd0, fwdA}, 32'd1);
    check("R4 load in wb", {30'd0, wbMemToReg, wbRegWrite}, 32'd3);
    drain();

    // R5: dependence through rt
    issue(4'd7, 5'd1, 5'd7, 5'd0);
    step();
    issue(4'd2, 5'd1, 5'd7, 5'd8);
    check("R5 stall on rt match", {31'd0, holdFetch}, 32'd1);
    drain();

    // R5: independent instruction after a load does not stall
    issue(4'd7, 5'd1, 5'd7, 5'd0);
    step();
    issue(4'd2, 5'd9, 5'd10, 5'd8);
    check("R5 no stall without match", {31'd0, holdFetch}, 32'd0);
    drain();

    // R9: load to register 0 never stalls
    issue(4'd7, 5'd2, 5'd0, 5'd0);
    step();
    issue(4'd1, 5'd0, 5'd0, 5'd6);
    check("R9 no stall on r0", {31'd0, holdFetch}, 32'd0);
    drain();

    // R7: back-to-back ALU dependence forwards from ex/mem, no stall
    issue(4'd1, 5'd1, 5'd2, 5'd5);
    step();
    issue(4'd2, 5'd5, 5'd5, 5'd6);
    check("R7 no stall for alu producer", {31'd0, holdFetch}, 32'd0);
    step();
    check("R7 fwdA ex/mem", {30'd0, fwdA}, 32'd2);
    check("R7 fwdB ex/mem", {30'd0, fwdB}, 32'd2);
    drain();

    // R8: two producers of r8, then a reader
    issue(4'd5, 5'd1, 5'd8, 5'd0);
    step();
    issue(4'd6, 5'd1, 5'd8, 5'd0);
    step();
    issue(4'd1, 5'd8, 5'd9, 5'd10);
    step();
    check("R8 priority ex/mem", {30'd0, fwdA}, 32'd2);
    check("R8 unrelated rt", {30'd0, fwdB}, 32'd0);
    drain();

    // R7: producer two ahead comes from mem/wb
    issue(4'd1, 5'd1, 5'd2, 5'd11);
    step();
    issue(4'd0, 5'd0, 5'd0, 5'd0);
    step();
    issue(4'd2, 5'd3, 5'd11, 5'd4);
    step();
    check("R7 fwdB mem/wb", {30'd0, fwdB}, 32'd1);
    drain();

    // R11: producer three ahead is not forwarded
    issue(4'd1, 5'd1, 5'd2, 5'd12);
    step();
    issue(4'd0, 5'd0, 5'd0, 5'd0);
    step();
    step();
    issue(4'd2, 5'd12, 5'd12, 5'd4);
    step();
    check("R11 no fwd after retire", {28'd0, fwdA, fwdB}, 32'd0);
    drain();

    // R9: writes to r0 are not forwarded
    issue(4'd1, 5'd1, 5'd2, 5'd0);
    step();
    issue(4'd2, 5'd0, 5'd0, 5'd4);
    step();
    check("R9 no fwd of r0", {28'd0, fwdA, fwdB}, 32'd0);
    drain();

    // R7: a store is not a producer
    issue(4'd8, 5'd1, 5'd13, 5'd0);
    step();
    issue(4'd1, 5'd13, 5'd13, 5'd4);
    step();
    check("R7 store not forwarded", {28'd0, fwdA, fwdB}, 32'd0);
    drain();

    // R10: reset in the middle of a stream
    issue(4'd7, 5'd1, 5'd3, 5'd0);
    step();
    issue(4'd1, 5'd3, 5'd3, 5'd6);
    step();
    rst = 1'b1;
    step();
    check("R10 mid reset ex", {27'd0, exPack()}, 32'd0);
    check("R10 mid reset mem/wb", {memWrite, memRead, memBranch, wbMemToReg, wbRegWrite}, 32'd0);
    check("R10 mid reset hold/fwd", {holdFetch, fwdA, fwdB}, 32'd0);
    rst = 1'b0;
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule